// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block is a bank of independent 16-bit timer channels. Each one can shape a pulse-width-modulated waveform on its own output pin. Software reaches every channel through a synchronous register port. A write is taken on the clock edge where the write strobe is high. A read returns data combinationally for the address currently presented.

Each channel has the following state:
- an up-counter that software can load directly;
- a duty compare value and a period compare value;
- a control word with an output enable, an idle-level select, a shutdown-style select and a clock-divider select.

Each pin rests at its idle level until the counter reaches the duty value. It then holds the opposite level until the counter reaches the period value. The counter wraps to zero on the next count, and the pin returns to idle at that wrap.

Counters are started through a shared set-strobe register and stopped through a shared clear-strobe register. A status register shows which counters are running. A channel's clock divider restarts each time its counter is started.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every channel has control 0, duty 16'hFFFF, period 0 and counter 0, no counter runs, and every pin is low.
- R2: With the output enabled and duty <= period, a pin shows the idle level while counter < duty and the opposite level while counter >= duty.
- R3: A running counter that equals the period value becomes 0 on its next count tick; otherwise a tick adds 1.
- R4: While duty > period, the pin stays at its idle level whatever the counter value.
- R5: Control bit 1 selects the idle level (1 = high), which inverts the whole waveform.
- R6: A write of 1 to bit c at address 0x20 starts channel c, and at address 0x21 stops it; 0 bits change nothing; address 0x22 reads the running set in bits [NCH-1:0].
- R7: A stopped counter holds its value; a software write to the counter loads the written value, and wins over a count or wrap in the same cycle.
- R8: With control bit 0 (output enable) clear and control bit 2 (abrupt) set, the pin shows the idle level.
- R9: Clearing the output enable with the abrupt bit set parks the pin on the next cycle. With the abrupt bit clear, the waveform carries on until the counter wraps, and then parks.
- R10: Control bits [5:3] pick the count rate: 0..5 give one tick every 1, 4, 16, 64, 256 or 1024 cycles, and 6 and 7 act as 5. The first tick comes the given number of cycles after the start write.
- R11: Channel c uses addresses 4c+0 (control), 4c+1 (duty), 4c+2 (period) and 4c+3 (counter), and each reads back what it holds. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 6 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_o | output | NCH | One waveform pin per channel |

## Verification
Two functions can land on the same clock edge: a software load of the counter, and the count tick that would wrap that counter from its period value to zero. The bench provokes this by starting a channel with a short period at divide-by-one. It counts edges until the counter reads back the period value, then issues the counter write on the very next edge. The result is judged correct only if the written value appears instead of zero, and the count then carries on and wraps normally from there.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int CTRL_W = 6;
  localparam int PRE_W  = 10;

  localparam logic [ADDR_W-1:0] A_START = 6'h20;
  localparam logic [ADDR_W-1:0] A_STOP  = 6'h21;
  localparam logic [ADDR_W-1:0] A_RUN   = 6'h22;

  typedef enum logic [1:0] {
    R_CTRL = 2'd0,
    R_DUTY = 2'd1,
    R_PER  = 2'd2,
    R_CNT  = 2'd3
  } chreg_e;

  // Control word; field order is the software-visible layout.
  typedef struct packed {
    logic [2:0] div_sel;
    logic       abrupt;
    logic       idle_hi;
    logic       out_en;
  } ctrl_t;

  // Low-bit mask of the divider counter: a tick occurs when all masked bits are 1.
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
    if (sel >= 3'd5) return '1;
    return PRE_W'((1 << (2 * int'(sel))) - 1);
  endfunction
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
  import ptb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(sel);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ptb_channel.sv
module ptb_channel
  import ptb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  chreg_e            reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] duty_o,
  output logic [DATA_W-1:0] per_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              pin_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] duty_q, per_q, cnt_q;
  logic              linger_q;
  logic              tick, wrap, active, gate;

  ptb_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (ctrl_q.div_sel),
    .tick (tick)
  );

  assign wrap   = tick && (cnt_q == per_q);
  assign active = (duty_q <= per_q) && (cnt_q >= duty_q);
  assign gate   = ctrl_q.out_en | (linger_q & ~ctrl_q.abrupt);
  assign pin_o  = ctrl_q.idle_hi ^ (gate & active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      duty_q   <= '1;
      per_q    <= '0;
      cnt_q    <= '0;
      linger_q <= 1'b0;
    end else begin
      if (wr_en && reg_sel == R_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && reg_sel == R_DUTY) duty_q <= wr_data;
      if (wr_en && reg_sel == R_PER)  per_q  <= wr_data;
      if (wr_en && reg_sel == R_CNT)  cnt_q  <= wr_data;
      else if (tick)                  cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      // Graceful drain: keeps the waveform alive after disable until the wrap.
      if (wrap || !run || ctrl_q.abrupt) linger_q <= 1'b0;
      else if (ctrl_q.out_en)            linger_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_sel)
      R_CTRL:  rd_data = DATA_W'(ctrl_q);
      R_DUTY:  rd_data = duty_q;
      R_PER:   rd_data = per_q;
      default: rd_data = cnt_q;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import ptb_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  localparam int IDX_W = 3;

  logic [NCH-1:0]             run_q;
  logic [NCH-1:0]             ch_hit;
  logic [NCH-1:0][DATA_W-1:0] ch_rd, ch_duty, ch_per, ch_cnt;
  logic [NCH-1:0]             ch_en, ch_idle, ch_abr;
  logic                       in_ch_space;

  assign in_ch_space = !bus_addr[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (bus_we && bus_addr == A_START) run_q <= run_q | bus_wdata[NCH-1:0];
    else if (bus_we && bus_addr == A_STOP)  run_q <= run_q & ~bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ctrl_t ctrl_w;
    assign ch_hit[i] = in_ch_space && (bus_addr[ADDR_W-2:2] == IDX_W'(i));

    ptb_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q[i]),
      .wr_en  (bus_we && ch_hit[i]),
      .reg_sel(chreg_e'(bus_addr[1:0])),
      .wr_data(bus_wdata),
      .rd_data(ch_rd[i]),
      .ctrl_o (ctrl_w),
      .duty_o (ch_duty[i]),
      .per_o  (ch_per[i]),
      .cnt_o  (ch_cnt[i]),
      .pin_o  (pwm_o[i])
    );

    assign ch_en[i]   = ctrl_w.out_en;
    assign ch_idle[i] = ctrl_w.idle_hi;
    assign ch_abr[i]  = ctrl_w.abrupt;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_RUN) begin
      bus_rdata[NCH-1:0] = run_q;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit[i]) bus_rdata = ch_rd[i];
      end
    end
  end
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker
  import ptb_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [NCH-1:0]             wbits,
  input logic [NCH-1:0]             pwm_o,
  input logic [NCH-1:0]             run_q,
  input logic [NCH-1:0][DATA_W-1:0] ch_duty,
  input logic [NCH-1:0][DATA_W-1:0] ch_per,
  input logic [NCH-1:0][DATA_W-1:0] ch_cnt,
  input logic [NCH-1:0]             ch_en,
  input logic [NCH-1:0]             ch_idle,
  input logic [NCH-1:0]             ch_abr
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic cnt_wr;
    assign cnt_wr = bus_we && !bus_addr[ADDR_W-1] &&
                    (bus_addr[ADDR_W-2:2] == 3'(i)) && (bus_addr[1:0] == 2'd3);

    a_r4_duty_above_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_duty[i] > ch_per[i]) |-> (pwm_o[i] == ch_idle[i]));

    a_r6_set_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_START && wbits[i]) |=> run_q[i]);

    a_r6_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_STOP && wbits[i]) |=> !run_q[i]);

    a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !cnt_wr) |=> $stable(ch_cnt[i]));

    a_r3_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[i] && ch_cnt[i] == ch_per[i] && !cnt_wr) |=>
        (ch_cnt[i] == '0 || $stable(ch_cnt[i])));

    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[i] && ch_abr[i]) |-> (pwm_o[i] == ch_idle[i]));
  end
endmodule

bind pwm_timer_bank ptb_checker #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .wbits   (bus_wdata[NCH-1:0]),
  .pwm_o   (pwm_o),
  .run_q   (run_q),
  .ch_duty (ch_duty),
  .ch_per  (ch_per),
  .ch_cnt  (ch_cnt),
  .ch_en   (ch_en),
  .ch_idle (ch_idle),
  .ch_abr  (ch_abr)
);

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb_top;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NCH-1:0] pwm_o;

  int nchk = 0;
  int nfail = 0;

  logic [15:0] sh_duty [NCH];
  logic [15:0] sh_per  [NCH];
  logic        sh_idle [NCH];
  logic        sh_en   [NCH];

  always #10 clk = ~clk;

  pwm_timer_bank #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  function automatic logic [5:0] ca(input int ch, input int r);
    return 6'(ch * 4 + r);
  endfunction

  function automatic logic [15:0] mk_ctrl(input logic en, input logic idle,
                                          input logic abr, input logic [2:0] sel);
    return {10'd0, sel, abr, idle, en};
  endfunction

  function automatic logic exp_pin(input logic idle, input logic en, input logic [15:0] duty,
                                   input logic [15:0] per, input logic [15:0] cnt);
    return idle ^ (en && duty <= per && cnt >= duty);
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next rising edge, returns at the following negedge.
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic setup(input int ch, input logic [15:0] ctrl, input logic [15:0] duty,
                       input logic [15:0] per);
    wr(ca(ch, 0), ctrl);
    wr(ca(ch, 1), duty);
    wr(ca(ch, 2), per);
    wr(ca(ch, 3), 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    logic parked;
    int div;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: reset values and readback map
    rd(6'h22, v); check("R1 run status", v, 16'h0);
    check("R1 pins", 16'(pwm_o), 16'h0);
    for (int c = 0; c < NCH; c++) begin
      rd(ca(c, 0), v); check("R1 ctrl", v, 16'h0000);
      rd(ca(c, 1), v); check("R1 duty", v, 16'hFFFF);
      rd(ca(c, 2), v); check("R1 period", v, 16'h0000);
      rd(ca(c, 3), v); check("R1 counter", v, 16'h0000);
      @(negedge clk);
    end
    rd(6'h30, v); check("R11 unmapped reads 0", v, 16'h0);
    @(negedge clk);
    wr(ca(7, 1), 16'hA5C3); rd(ca(7, 1), v); check("R11 duty readback", v, 16'hA5C3);
    wr(ca(7, 1), 16'hFFFF);

    // R6: set / clear strobes, zero bits ignored
    wr(6'h20, 16'h0000); rd(6'h22, v); check("R6 zero set ignored", v, 16'h0);
    wr(6'h20, 16'h0004); rd(6'h22, v); check("R6 set bit2", v, 16'h0004);
    wr(6'h21, 16'h0000); rd(6'h22, v); check("R6 zero clear ignored", v, 16'h0004);
    wr(6'h21, 16'h0004); rd(6'h22, v); check("R6 clear bit2", v, 16'h0000);

    // R3 / R2: divide-by-1 count with wrap, pin follows duty
    setup(0, mk_ctrl(1, 0, 1, 3'd0), 16'd3, 16'd5);
    wr(6'h20, 16'h0001);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      rd(ca(0, 3), v);
      check("R3 count/wrap", v, 16'(k % 6));
      check("R2 pin phase", 16'(pwm_o[0]), 16'(exp_pin(0, 1, 16'd3, 16'd5, v)));
    end
    wr(6'h21, 16'h0001);
    rd(ca(0, 3), v);
    repeat (5) @(negedge clk);
    rd(ca(0, 3), v2); check("R7 stopped counter holds", v2, v);

    // R7: counter write on the same edge as a wrap
    setup(1, mk_ctrl(1, 0, 1, 3'd0), 16'd1, 16'd3);
    wr(6'h20, 16'h0002);
    repeat (3) @(negedge clk);
    rd(ca(1, 3), v); check("R7 at period before write", v, 16'd3);
    wr(ca(1, 3), 16'd2);
    rd(ca(1, 3), v); check("R7 write beats wrap", v, 16'd2);
    @(negedge clk); rd(ca(1, 3), v); check("R7 counts after write", v, 16'd3);
    @(negedge clk); rd(ca(1, 3), v); check("R3 wrap after write", v, 16'd0);
    wr(6'h21, 16'h0002);

    // R10: divider settings
    for (int s = 0; s <= 5; s++) begin
      div = (s == 5) ? 1024 : (1 << (2 * s));
      setup(3, mk_ctrl(0, 0, 1, 3'(s)), 16'hFFFF, 16'hFFFF);
      wr(6'h20, 16'h0008);
      repeat (3 * div - 1) @(negedge clk);
      rd(ca(3, 3), v); check("R10 before third tick", v, 16'd2);
      @(negedge clk);
      rd(ca(3, 3), v); check("R10 third tick", v, 16'd3);
      wr(6'h21, 16'h0008);
    end
    setup(3, mk_ctrl(0, 0, 1, 3'd7), 16'hFFFF, 16'hFFFF);
    wr(6'h20, 16'h0008);
    repeat (1023) @(negedge clk);
    rd(ca(3, 3), v); check("R10 sel7 as 1024 before", v, 16'd0);
    @(negedge clk);
    rd(ca(3, 3), v); check("R10 sel7 as 1024 tick", v, 16'd1);
    wr(6'h21, 16'h0008);

    // R4: duty above period never leaves idle
    setup(4, mk_ctrl(1, 0, 1, 3'd0), 16'd9, 16'd4);
    wr(6'h20, 16'h0010);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      check("R4 parked", 16'(pwm_o[4]), 16'd0);
    end
    wr(ca(4, 3), 16'd20);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      check("R4 parked counter above both", 16'(pwm_o[4]), 16'd0);
    end
    wr(6'h21, 16'h0010);

    // R5: idle-high inverts
    setup(5, mk_ctrl(1, 1, 1, 3'd0), 16'd2, 16'd7);
    wr(6'h20, 16'h0020);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rd(ca(5, 3), v);
      check("R5 inverted phase", 16'(pwm_o[5]), 16'(exp_pin(1, 1, 16'd2, 16'd7, v)));
    end

    // R8: output disabled shows idle level
    wr(ca(5, 0), mk_ctrl(0, 1, 1, 3'd0));
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #1;
      check("R8 disabled idle high", 16'(pwm_o[5]), 16'd1);
    end
    wr(6'h21, 16'h0020);

    // R9: graceful disable finishes the period
    setup(6, mk_ctrl(1, 0, 0, 3'd0), 16'd2, 16'd9);
    wr(6'h20, 16'h0040);
    repeat (5) @(negedge clk);
    wr(ca(6, 0), mk_ctrl(0, 0, 0, 3'd0));
    rd(ca(6, 3), v);
    check("R9 graceful still active", 16'(pwm_o[6]), 16'd1);
    parked = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rd(ca(6, 3), v);
      if (v == 16'd0) parked = 1'b1;
      check("R9 graceful drain", 16'(pwm_o[6]), parked ? 16'd0 : 16'(v >= 16'd2));
    end
    // R9: abrupt disable
    wr(ca(6, 0), mk_ctrl(1, 0, 1, 3'd0));
    for (int k = 0; k < 20; k++) begin
      rd(ca(6, 3), v);
      if (v == 16'd5) break;
      @(negedge clk);
    end
    wr(ca(6, 0), mk_ctrl(0, 0, 1, 3'd0));
    for (int k = 0; k < 10; k++) begin
      #1;
      check("R9 abrupt parks at once", 16'(pwm_o[6]), 16'd0);
      @(negedge clk);
    end
    wr(6'h21, 16'h0040);

    // R2: constrained random configurations, all channels running
    for (int c = 0; c < NCH; c++) begin
      sh_duty[c] = 16'($urandom_range(0, 15));
      sh_per[c]  = 16'($urandom_range(0, 15));
      sh_idle[c] = 1'($urandom_range(0, 1));
      sh_en[c]   = 1'($urandom_range(0, 1));
      setup(c, mk_ctrl(sh_en[c], sh_idle[c], 1, 3'd0), sh_duty[c], sh_per[c]);
    end
    wr(6'h20, 16'h00FF);
    for (int it = 0; it < 30; it++) begin
      int c;
      c = $urandom_range(0, NCH - 1);
      sh_duty[c] = 16'($urandom_range(0, 15));
      sh_per[c]  = 16'($urandom_range(0, 15));
      sh_idle[c] = 1'($urandom_range(0, 1));
      sh_en[c]   = 1'($urandom_range(0, 1));
      wr(ca(c, 0), mk_ctrl(sh_en[c], sh_idle[c], 1, 3'd0));
      wr(ca(c, 1), sh_duty[c]);
      wr(ca(c, 2), sh_per[c]);
      for (int k = 0; k < 40; k++) begin
        int ch;
        @(negedge clk);
        ch = k % NCH;
        rd(ca(ch, 3), v);
        check("R2 random phase", 16'(pwm_o[ch]),
              16'(exp_pin(sh_idle[ch], sh_en[ch], sh_duty[ch], sh_per[ch], v)));
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule